// File: doc/BRIEF.md
# Hit Register Scan Formatter

This block turns the hit register produced by a bank of road comparators into a stream of 32-bit output words. Each time a new hit register is offered, it is captured together with its group flags, the centroid it belongs to, the index of the last loaded road and an end-of-event flag. The block then walks the captured register one road per clock. The walk begins at a start road taken from the group flags and stops at the last loaded road, not at the full register width. Every set bit produces a hit word, written in the same cycle to a trace buffer port and to an output FIFO port.

When the walk is over, the block raises done for one cycle and returns to waiting for the next hit register. If the captured register closes an event, a trailer word carrying the number of hits written during that event goes out on both ports first, in the same cycle as done. A full output FIFO holds the block in place. No word is dropped, and the road under inspection is not skipped.

Top module: `hit_scan_fmt`

## Requirements
- R1: While reset is asserted and after it is released, with no hit register offered, neither write port is active and done stays low.
- R2: A hit register, its group flags, centroid, last road index and end-of-event flag are captured only in a cycle where `hitreg_valid_i` is high while the block is idle. A `hitreg_valid_i` pulse during a scan has no effect on the words written.
- R3: The scan starts at road `g * (N_ROADS / N_GROUPS)`, where `g` is the lowest group flag that is set, or at road 0 when no group flag is set.
- R4: The block inspects one road per cycle, in ascending order, from the start road up to and including `last_road_i`. Each set bit produces the hit word `{8'hA5, road index[7:0], centroid[15:0]}`. Set bits outside that range produce nothing.
- R5: Every word is written to the trace port and the FIFO port in the same cycle, with identical data.
- R6: If the captured register has no set bit within the scan range, no hit word is written, and done is raised in the cycle right after the capture. A trailer is still written first when end of event is flagged.
- R7: While `ofifo_full_i` is high, no word is written and the current road is held. The word is written once the FIFO is no longer full.
- R8: done is high for exactly one cycle per captured hit register, in the cycle the scan completes. No write occurs in the following cycle.
- R9: When end of event is flagged, the final write of the scan is the trailer `{8'hFF, count[7:0], 16'h0000}`, in the same cycle as done. The count is the number of hit words written since the previous trailer, taken modulo 256. It restarts from zero after the trailer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hitreg_valid_i | input | 1 | New hit register offered |
| hit_vec_i | input | N_ROADS (32) | Comparator hit bits, one per road |
| group_i | input | N_GROUPS (4) | Group flags choosing the start road |
| centroid_i | input | 16 | Centroid the hits belong to |
| last_road_i | input | $clog2(N_ROADS) (5) | Index of the last loaded road |
| eoe_i | input | 1 | This hit register closes the event |
| ofifo_full_i | input | 1 | Output FIFO cannot accept a word |
| trc_we_o | output | 1 | Trace buffer write strobe |
| trc_data_o | output | 32 | Trace buffer write data |
| ofifo_we_o | output | 1 | Output FIFO write strobe |
| ofifo_data_o | output | 32 | Output FIFO write data |
| done_o | output | 1 | Scan complete, one-cycle pulse |

## Verification
The bench targets several edge cases.

- **Range limits.** It probes a last road index below the start road, a scan that begins mid-register, and hits lying beyond the last loaded road. A design that scanned the full width would emit extra words. One that started at road 0 would emit words below the group start.
- **FIFO full.** Full is toggled against dense hit patterns and held high through a trailer. A design that advanced on full would lose hits. One that wrote while full would duplicate or overflow them.
- **Event counting.** The trailer count is checked across several hit registers of one event and again after a trailer. This catches a count that is reset per scan, or one that is never cleared.
- **Late valid.** A valid pulse in the middle of a scan must leave the word stream untouched.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int WORD_W = 32;
  localparam int CEN_W  = 16;
  localparam logic [7:0] HIT_TAG = 8'hA5;
  localparam logic [7:0] TRL_TAG = 8'hFF;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIN  = 2'd2
  } hs_state_e;
endpackage

// File: rtl/hs_rst_sync.sv
module hs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/hs_start_sel.sv
module hs_start_sel #(
  parameter int N_ROADS  = 32,
  parameter int N_GROUPS = 4
) (
  input  logic [N_GROUPS-1:0]        group_i,
  output logic [$clog2(N_ROADS)-1:0] start_o
);
  localparam int IDX_W  = $clog2(N_ROADS);
  localparam int GRP_SZ = N_ROADS / N_GROUPS;

  // Walk from the top group down so the lowest set flag wins.
  always_comb begin
    start_o = '0;
    for (int g = N_GROUPS - 1; g >= 0; g--) begin
      if (group_i[g]) start_o = IDX_W'(g * GRP_SZ);
    end
  end
endmodule

// File: rtl/hs_range_any.sv
module hs_range_any #(
  parameter int N_ROADS = 32
) (
  input  logic [N_ROADS-1:0]         hit_i,
  input  logic [$clog2(N_ROADS)-1:0] lo_i,
  input  logic [$clog2(N_ROADS)-1:0] hi_i,
  output logic                       any_o
);
  localparam int IDX_W = $clog2(N_ROADS);

  logic [N_ROADS-1:0] in_rng;

  for (genvar i = 0; i < N_ROADS; i++) begin : g_bit
    assign in_rng[i] = hit_i[i] && (IDX_W'(i) >= lo_i) && (IDX_W'(i) <= hi_i);
  end

  assign any_o = |in_rng;
endmodule

// File: rtl/hs_word_fmt.sv
module hs_word_fmt
  import hs_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              trailer_i,
  input  logic [IDX_W-1:0]  road_i,
  input  logic [CEN_W-1:0]  centroid_i,
  input  logic [7:0]        count_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    if (trailer_i) word_o = {TRL_TAG, count_i, 16'h0000};
    else           word_o = {HIT_TAG, 8'(road_i), centroid_i};
  end
endmodule

// File: rtl/hit_scan_fmt.sv
module hit_scan_fmt
  import hs_pkg::*;
#(
  parameter int N_ROADS  = 32,
  parameter int N_GROUPS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        hitreg_valid_i,
  input  logic [N_ROADS-1:0]          hit_vec_i,
  input  logic [N_GROUPS-1:0]         group_i,
  input  logic [15:0]                 centroid_i,
  input  logic [$clog2(N_ROADS)-1:0]  last_road_i,
  input  logic                        eoe_i,
  input  logic                        ofifo_full_i,
  output logic                        trc_we_o,
  output logic [31:0]                 trc_data_o,
  output logic                        ofifo_we_o,
  output logic [31:0]                 ofifo_data_o,
  output logic                        done_o
);
  localparam int IDX_W = $clog2(N_ROADS);

  logic rst_int_n;

  hs_state_e          st_q, st_d;
  logic [N_ROADS-1:0] hits_q;
  logic [CEN_W-1:0]   cen_q;
  logic [IDX_W-1:0]   last_q;
  logic               eoe_q;
  logic [IDX_W-1:0]   ptr_q, ptr_d;
  logic [7:0]         cnt_q;

  logic               ld_en;
  logic               ptr_en;
  logic               wr;
  logic               trl_sel;
  logic               cnt_inc;
  logic               cnt_clr;
  logic               done;
  logic               cur_bit;
  logic [IDX_W-1:0]   start_idx;
  logic               any_hit;
  logic [WORD_W-1:0]  word;

  hs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  hs_start_sel #(.N_ROADS(N_ROADS), .N_GROUPS(N_GROUPS)) u_start (
    .group_i (group_i),
    .start_o (start_idx)
  );

  hs_range_any #(.N_ROADS(N_ROADS)) u_any (
    .hit_i (hit_vec_i),
    .lo_i  (start_idx),
    .hi_i  (last_road_i),
    .any_o (any_hit)
  );

  hs_word_fmt #(.IDX_W(IDX_W)) u_fmt (
    .trailer_i  (trl_sel),
    .road_i     (ptr_q),
    .centroid_i (cen_q),
    .count_i    (cnt_q),
    .word_o     (word)
  );

  assign cur_bit = hits_q[ptr_q];

  // Next-state and control decode
  always_comb begin
    st_d    = st_q;
    ptr_d   = ptr_q;
    ptr_en  = 1'b0;
    ld_en   = 1'b0;
    wr      = 1'b0;
    trl_sel = 1'b0;
    cnt_inc = 1'b0;
    cnt_clr = 1'b0;
    done    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (hitreg_valid_i) begin
          ld_en  = 1'b1;
          ptr_en = 1'b1;
          ptr_d  = start_idx;
          st_d   = any_hit ? ST_SCAN : ST_FIN;
        end
      end
      ST_SCAN: begin
        if (cur_bit && !ofifo_full_i) begin
          wr      = 1'b1;
          cnt_inc = 1'b1;
        end
        if (!cur_bit || !ofifo_full_i) begin
          if (ptr_q == last_q) begin
            st_d = ST_FIN;
          end else begin
            ptr_en = 1'b1;
            ptr_d  = ptr_q + IDX_W'(1);
          end
        end
      end
      ST_FIN: begin
        trl_sel = eoe_q;
        if (eoe_q) begin
          if (!ofifo_full_i) begin
            wr      = 1'b1;
            done    = 1'b1;
            cnt_clr = 1'b1;
            st_d    = ST_IDLE;
          end
        end else begin
          done = 1'b1;
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) st_q <= ST_IDLE;
    else            st_q <= st_d;
  end

  // Capture registers, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hits_q <= '0;
      cen_q  <= '0;
      last_q <= '0;
      eoe_q  <= 1'b0;
    end else if (ld_en) begin
      hits_q <= hit_vec_i;
      cen_q  <= centroid_i;
      last_q <= last_road_i;
      eoe_q  <= eoe_i;
    end
  end

  // Scan pointer
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  // Event hit counter
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   cnt_q <= '0;
    else if (cnt_clr) cnt_q <= '0;
    else if (cnt_inc) cnt_q <= cnt_q + 8'd1;
  end

  assign trc_we_o     = wr;
  assign trc_data_o   = word;
  assign ofifo_we_o   = wr;
  assign ofifo_data_o = word;
  assign done_o       = done;
endmodule

// File: rtl/hs_chk.sv
module hs_chk #(
  parameter int N_ROADS = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ofifo_full_i,
  input logic                       ofifo_we_o,
  input logic [31:0]                ofifo_data_o,
  input logic                       done_o,
  input logic [$clog2(N_ROADS)-1:0] last_q
);
  AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ofifo_full_i |-> !ofifo_we_o); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !ofifo_we_o); // R8

  AST_WORD_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    ofifo_we_o |-> (ofifo_data_o[31:24] == 8'hA5 || ofifo_data_o[31:24] == 8'hFF)); // R4

  AST_ROAD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (ofifo_we_o && ofifo_data_o[31:24] == 8'hA5) |-> (ofifo_data_o[23:16] <= 8'(last_q))); // R4

  AST_TRAILER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ofifo_we_o && ofifo_data_o[31:24] == 8'hFF) |-> done_o); // R9
endmodule

bind hit_scan_fmt hs_chk #(.N_ROADS(N_ROADS)) u_hs_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ofifo_full_i (ofifo_full_i),
  .ofifo_we_o   (ofifo_we_o),
  .ofifo_data_o (ofifo_data_o),
  .done_o       (done_o),
  .last_q       (last_q)
);

// File: tb/hit_scan_fmt_tb_top.sv
`timescale 1ns/1ps
module hit_scan_fmt_tb_top;
  logic        clk;
  logic        rst_n;
  logic        valid;
  logic [31:0] hits;
  logic [3:0]  grp;
  logic [15:0] cen;
  logic [4:0]  last;
  logic        eoe;
  logic        full;
  logic        trc_we;
  logic [31:0] trc_data;
  logic        ofifo_we;
  logic [31:0] ofifo_data;
  logic        done;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit full_en    = 0;
  bit full_force = 0;
  bit finished   = 0;

  // reference model state
  int          m_st = 0;
  logic [31:0] m_hits;
  logic [15:0] m_cen;
  int          m_last;
  bit          m_eoe;
  int          m_pos;
  int          m_cnt = 0;

  logic [31:0] got[$];
  logic [31:0] expq[$];
  int          done_cnt = 0;
  int          ev_cnt = 0;

  hit_scan_fmt dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .hitreg_valid_i (valid),
    .hit_vec_i      (hits),
    .group_i        (grp),
    .centroid_i     (cen),
    .last_road_i    (last),
    .eoe_i          (eoe),
    .ofifo_full_i   (full),
    .trc_we_o       (trc_we),
    .trc_data_o     (trc_data),
    .ofifo_we_o     (ofifo_we),
    .ofifo_data_o   (ofifo_data),
    .done_o         (done)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic int start_of(input logic [3:0] g);
    for (int k = 0; k < 4; k++) if (g[k]) return k * 8;
    return 0;
  endfunction

  // model advance on each edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0;
    end else begin
      case (m_st)
        0: if (valid) begin
          bit any;
          m_hits = hits; m_cen = cen; m_last = int'(last); m_eoe = eoe;
          m_pos = start_of(grp);
          any = 0;
          for (int i = m_pos; i <= m_last; i++) if (hits[i]) any = 1;
          m_st = any ? 1 : 2;
        end
        1: begin
          if (m_hits[m_pos] && !full) m_cnt++;
          if (!m_hits[m_pos] || !full) begin
            if (m_pos == m_last) m_st = 2; else m_pos++;
          end
        end
        default: begin
          if (!m_eoe) m_st = 0;
          else if (!full) begin m_cnt = 0; m_st = 0; end
        end
      endcase
    end
  end

  // per-cycle comparison away from the edge
  always @(negedge clk) begin
    bit          e_we, e_done;
    logic [31:0] e_data;
    string       tag;
    e_we = 0; e_done = 0; e_data = '0;
    tag = !rst_n ? "R1 reset" : "R2 idle";
    if (m_st == 1) begin
      tag = (m_hits[m_pos] && full) ? "R7 stall" : "R4 scan";
      e_we = m_hits[m_pos] && !full;
      e_data = {8'hA5, 8'(m_pos), m_cen};
    end else if (m_st == 2) begin
      if (m_eoe) begin
        tag = "R9 trailer";
        e_we = !full; e_done = !full;
        e_data = {8'hFF, 8'(m_cnt), 16'h0};
      end else begin
        tag = "R8 done";
        e_done = 1;
      end
    end
    chk(ofifo_we === e_we, {tag, " fifo we"}, 32'(ofifo_we), 32'(e_we));
    chk(trc_we === e_we, {"R5 ", tag, " trace we"}, 32'(trc_we), 32'(e_we));
    if (e_we) begin
      chk(ofifo_data === e_data, {tag, " fifo data"}, ofifo_data, e_data);
      chk(trc_data === e_data, {"R5 ", tag, " trace data"}, trc_data, e_data);
    end
    chk(done === e_done, {tag, " done"}, 32'(done), 32'(e_done));
    if (rst_n && ofifo_we === 1'b1) got.push_back(ofifo_data);
    if (rst_n && done === 1'b1) done_cnt++;
  end

  // FIFO full stimulus
  initial begin
    full = 0;
    forever begin
      @(posedge clk); #1;
      if (full_force) full = 1;
      else if (full_en) full = ((cyc * 7) % 5) < 2;
      else full = 0;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    finish_run();
  end

  task automatic run_scan(input logic [31:0] h, input logic [3:0] g, input int lst,
                          input bit e, input logic [15:0] c, input bit poke, input string tag);
    int s;
    s = start_of(g);
    expq.delete();
    for (int i = s; i <= lst; i++) begin
      if (h[i]) begin
        expq.push_back({8'hA5, 8'(i), c});
        ev_cnt++;
      end
    end
    if (e) begin
      expq.push_back({8'hFF, 8'(ev_cnt), 16'h0});
      ev_cnt = 0;
    end
    got.delete();
    done_cnt = 0;
    @(posedge clk); #1;
    hits = h; grp = g; last = 5'(lst); eoe = e; cen = c; valid = 1;
    @(posedge clk); #1;
    valid = 0;
    if (poke) begin
      @(posedge clk); #1;
      hits = 32'hFFFF_FFFF; grp = 4'b0000; last = 5'd31; eoe = 1; cen = 16'hDEAD; valid = 1;
      @(posedge clk); #1;
      valid = 0;
    end
    while (m_st != 0) @(posedge clk);
    #2;
    chk(got.size() == expq.size(), {tag, " word count"}, 32'(got.size()), 32'(expq.size()));
    for (int i = 0; i < expq.size() && i < got.size(); i++)
      chk(got[i] === expq[i], {tag, " word"}, got[i], expq[i]);
    chk(done_cnt == 1, {"R8 ", tag, " done pulses"}, 32'(done_cnt), 32'd1);
  endtask

  initial begin
    rst_n = 0; valid = 0; hits = '0; grp = '0; cen = '0; last = '0; eoe = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (6) @(posedge clk);
    // R1: outputs quiet after reset release
    #2 chk(ofifo_we === 1'b0 && done === 1'b0, "R1 quiet after reset", 32'(ofifo_we), 32'd0);

    run_scan(32'h8001_0421, 4'b0000, 31, 0, 16'h1234, 0, "R4 full width");
    run_scan(32'hFFFF_FFFF, 4'b0100, 20, 0, 16'h0BEE, 0, "R3 group start");
    run_scan(32'hFF00_00FF, 4'b0110, 27, 0, 16'h0042, 0, "R3 lowest group wins");
    run_scan(32'h0000_000F, 4'b0010, 31, 0, 16'h5555, 0, "R6 no hit in range");
    run_scan(32'h0000_00F0, 4'b0000, 3, 0, 16'h7777, 0, "R4 hits past last road");
    full_en = 1;
    run_scan(32'hAAAA_5555, 4'b0000, 31, 1, 16'hC0DE, 0, "R7 stall with trailer R9");
    run_scan(32'hF0F0_F0F0, 4'b0001, 30, 0, 16'h0101, 1, "R2 valid during scan");
    full_en = 0;
    run_scan(32'h0000_0F00, 4'b0000, 15, 0, 16'h2222, 0, "R9 event part one");
    run_scan(32'h8000_0001, 4'b1000, 3, 1, 16'h3333, 0, "R6 empty range with trailer R9");
    run_scan(32'h0000_0000, 4'b0000, 31, 1, 16'h4444, 0, "R9 zero count trailer");

    // trailer held off by a full FIFO for several cycles
    fork
      run_scan(32'h0000_0003, 4'b0000, 1, 1, 16'h9999, 0, "R7 trailer held R9");
      begin
        repeat (4) @(posedge clk);
        full_force = 1;
        repeat (6) @(posedge clk);
        full_force = 0;
      end
    join

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule